// File: doc/BRIEF.md
# Microcontroller Idle and Power-Down Controller

This block holds the power-mode control byte of an 8-bit microcontroller core and turns it into two clock enables: one for the CPU and one for the peripherals. Software puts the core into a low-power state with a single byte write to a special-function address. In idle the CPU clock stops while interrupts, timers and serial ports stay clocked. In power-down both enables drop, which models the stopped oscillator. Two general-purpose flag bits share the byte so that an interrupt handler can tell whether it woke the core from idle.

Idle ends when an enabled interrupt request arrives and its priority is above everything currently in service. A long enough external reset pulse or a watchdog strobe also ends it. Power-down ends only through the two external interrupt lines, and each line has its own qualification length. The reset paths clear the control byte and drive a core-reset output. For a watchdog strobe that output is held for a fixed number of machine cycles, timed by a free-running machine-cycle divider.

Top module: `pm_ctrl`

## Requirements
- R1: After the asynchronous reset `rst_n` is released, the control byte reads 0x00, both clock enables are 1 and `core_rst` is 0.
- R2: The control byte is reached only at address 0x87, with whole-byte reads and writes. Bit 0 is idle, bit 1 is power-down, bit 2 is flag A and bit 3 is flag B. Bits 7:4 read 0. A read at any other address returns 0, and a write to any other address changes nothing.
- R3: A write with bit 0 = 1 and bit 1 = 0 sets idle. From the next cycle `cpu_clk_en` is 0 and `per_clk_en` stays 1.
- R4: A write with bit 1 = 1 sets power-down, and from the next cycle both enables are 0. If bit 0 is also 1 in that write, idle stays 0.
- R5: While idle is set, a request line `i` with `irq_req[i]` = 1 and `irq_en[i]` = 1 clears idle at the next edge, under a priority condition. A high-priority request (`irq_prio[i]` = 1) needs `insvc_hi` = 0. A low-priority request needs both `insvc_hi` and `insvc_lo` = 0.
- R6: Idle is not cleared by a request that is disabled, or by one blocked by an in-service interrupt of equal or higher priority.
- R7: Flag bits A and B are plain read/write storage. Interrupt wake-ups do not change them.
- R8: An external reset is accepted in the 24th consecutive cycle that `ext_rst_in` is sampled as 1, that is two machine cycles of 12 clocks. In that cycle `core_rst` rises and the byte is cleared at the edge. `core_rst` stays 1 until the pin falls. Shorter pulses have no effect.
- R9: A `wdt_rst` strobe clears the byte and sets `core_rst` from the next cycle. `core_rst` is released after three machine ticks. A tick is a 12-clock free-running count started at reset release, first occurring in the 12th cycle.
- R10: While in power-down, request line 0 (enabled) held for 2 consecutive cycles, or request line 2 (enabled) held for 1 cycle, clears power-down at that edge. No other line ends power-down.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| sfr_addr | input | 8 | Special-function bus address |
| sfr_wr | input | 1 | Write strobe |
| sfr_wdata | input | 8 | Write data |
| sfr_rdata | output | 8 | Read data, control byte when the address matches |
| irq_req | input | 7 | Interrupt request lines |
| irq_en | input | 7 | Per-line interrupt enables |
| irq_prio | input | 7 | Per-line priority, 1 = high |
| insvc_hi | input | 1 | A high-priority interrupt is in service |
| insvc_lo | input | 1 | A low-priority interrupt is in service |
| ext_rst_in | input | 1 | External reset pin, active high |
| wdt_rst | input | 1 | Watchdog reset strobe |
| cpu_clk_en | output | 1 | CPU clock enable |
| per_clk_en | output | 1 | Peripheral clock enable |
| core_rst | output | 1 | Reset to the core, active high |

## Verification
On every cycle the assertions check the following. A mode write gates the right clocks on the next edge. Idle and power-down are never set together. A qualifying wake-up reopens the CPU clock. A blocking in-service level suppresses the idle wake. An accepted external reset follows a held pin, and a watchdog strobe raises the core reset. Only the bench's scenarios can show the exact lengths involved: the 24-cycle hold threshold, the three-tick restart window, and the two-cycle against one-cycle power-down qualification. Those rest on counts that a per-cycle behavioural model follows.

// File: rtl/pm_pkg.sv
package pm_pkg;
   localparam int unsigned CTL_DW   = 8;
   localparam int unsigned IDLE_POS = 0;
   localparam int unsigned PD_POS   = 1;
   localparam int unsigned FLGA_POS = 2;
   localparam int unsigned FLGB_POS = 3;

   typedef struct packed {
      logic flg_b;
      logic flg_a;
      logic pd;
      logic idle;
   } pm_ctl_t;
endpackage

// File: rtl/pm_tick_gen.sv
module pm_tick_gen #(
   parameter int unsigned MC_LEN = 12
) (
   input  logic clk,
   input  logic rst_n,
   output logic tick
);
   localparam int unsigned CW = $clog2(MC_LEN);

   generate
      if (MC_LEN < 2) begin : g_bad_len
         $error("pm_tick_gen: MC_LEN must be at least 2");
      end
   endgenerate

   logic [CW-1:0] cnt_q;

   assign tick = (cnt_q == CW'(MC_LEN - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    cnt_q <= '0;
      else if (tick) cnt_q <= '0;
      else           cnt_q <= cnt_q + CW'(1);
   end

   a_r9_tick_spacing: assert property (@(posedge clk) disable iff (!rst_n)
      tick |=> !tick);
endmodule

// File: rtl/pm_reset_exit.sv
module pm_reset_exit #(
   parameter int unsigned HOLD_CLKS  = 24,
   parameter int unsigned RESTART_MC = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   input  logic ext_rst_in,
   input  logic wdt_rst,
   output logic clr,
   output logic core_rst
);
   localparam int unsigned HW = $clog2(HOLD_CLKS);
   localparam int unsigned RW = $clog2(RESTART_MC + 1);
   localparam logic [HW-1:0] HOLD_MAX = HW'(HOLD_CLKS - 1);

   generate
      if (HOLD_CLKS < 2) begin : g_bad_hold
         $error("pm_reset_exit: HOLD_CLKS must be at least 2");
      end
      if (RESTART_MC < 1) begin : g_bad_restart
         $error("pm_reset_exit: RESTART_MC must be at least 1");
      end
   endgenerate

   logic [HW-1:0] hold_q;
   logic [RW-1:0] rs_q;
   logic          ext_acc;

   assign ext_acc  = ext_rst_in && (hold_q == HOLD_MAX);
   assign clr      = ext_acc || wdt_rst;
   assign core_rst = ext_acc || (rs_q != '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 hold_q <= '0;
      else if (!ext_rst_in)       hold_q <= '0;
      else if (hold_q != HOLD_MAX) hold_q <= hold_q + HW'(1);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                    rs_q <= '0;
      else if (wdt_rst)              rs_q <= RW'(RESTART_MC);
      else if (tick && rs_q != '0)   rs_q <= rs_q - RW'(1);
   end

   a_r8_hold_pin_high: assert property (@(posedge clk) disable iff (!rst_n)
      ext_acc |-> (ext_rst_in && $past(ext_rst_in)));
   a_r9_wdt_holds_core: assert property (@(posedge clk) disable iff (!rst_n)
      wdt_rst |=> core_rst);
endmodule

// File: rtl/pm_wake.sv
module pm_wake #(
   parameter int unsigned N_SRC    = 7,
   parameter int unsigned PD_IDX_A = 0,
   parameter int unsigned PD_IDX_B = 2,
   parameter int unsigned PD_CYC_A = 2,
   parameter int unsigned PD_CYC_B = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             pd,
   input  logic [N_SRC-1:0] irq_req,
   input  logic [N_SRC-1:0] irq_en,
   input  logic [N_SRC-1:0] irq_prio,
   input  logic             insvc_hi,
   input  logic             insvc_lo,
   output logic             idle_wake,
   output logic             pd_wake
);
   localparam int unsigned PD_IDX [2] = '{PD_IDX_A, PD_IDX_B};
   localparam int unsigned PD_CYC [2] = '{PD_CYC_A, PD_CYC_B};

   generate
      if (PD_IDX_A >= N_SRC || PD_IDX_B >= N_SRC) begin : g_bad_idx
         $error("pm_wake: power-down wake index outside request range");
      end
   endgenerate

   logic [N_SRC-1:0] allowed;

   always_comb begin
      for (int i = 0; i < N_SRC; i++) begin
         allowed[i] = irq_prio[i] ? !insvc_hi : !(insvc_hi || insvc_lo);
      end
   end

   assign idle_wake = |(irq_req & irq_en & allowed);

   logic [1:0] line_wake;

   for (genvar k = 0; k < 2; k++) begin : g_pd_line
      logic line_on;
      assign line_on = pd && irq_req[PD_IDX[k]] && irq_en[PD_IDX[k]];
      if (PD_CYC[k] <= 1) begin : g_direct
         assign line_wake[k] = line_on;
      end else begin : g_counted
         localparam int unsigned QW = $clog2(PD_CYC[k]);
         localparam logic [QW-1:0] QMAX = QW'(PD_CYC[k] - 1);
         logic [QW-1:0] q_cnt;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)            q_cnt <= '0;
            else if (!line_on)     q_cnt <= '0;
            else if (q_cnt != QMAX) q_cnt <= q_cnt + QW'(1);
         end
         assign line_wake[k] = line_on && (q_cnt == QMAX);
      end
   end

   assign pd_wake = |line_wake;

   a_r6_hi_service_blocks: assert property (@(posedge clk) disable iff (!rst_n)
      insvc_hi |-> !idle_wake);
   a_r10_pd_wake_needs_pd: assert property (@(posedge clk) disable iff (!rst_n)
      pd_wake |-> pd);
endmodule

// File: rtl/pm_ctrl.sv
module pm_ctrl #(
   parameter logic [7:0]  SFR_ADDR   = 8'h87,
   parameter int unsigned N_SRC      = 7,
   parameter int unsigned MC_LEN     = 12,
   parameter int unsigned HOLD_MC    = 2,
   parameter int unsigned RESTART_MC = 3,
   parameter int unsigned X0_IDX     = 0,
   parameter int unsigned X1_IDX     = 2,
   parameter int unsigned X0_CYC     = 2,
   parameter int unsigned X1_CYC     = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [7:0]       sfr_addr,
   input  logic             sfr_wr,
   input  logic [7:0]       sfr_wdata,
   output logic [7:0]       sfr_rdata,
   input  logic [N_SRC-1:0] irq_req,
   input  logic [N_SRC-1:0] irq_en,
   input  logic [N_SRC-1:0] irq_prio,
   input  logic             insvc_hi,
   input  logic             insvc_lo,
   input  logic             ext_rst_in,
   input  logic             wdt_rst,
   output logic             cpu_clk_en,
   output logic             per_clk_en,
   output logic             core_rst
);
   import pm_pkg::*;

   localparam int unsigned HOLD_CLKS = HOLD_MC * MC_LEN;

   logic    tick, clr, idle_wake, pd_wake, addr_hit, hit_wr;
   pm_ctl_t ctl_q;
   logic    wdata_unused;

   assign wdata_unused = ^sfr_wdata[7:4];
   assign addr_hit     = (sfr_addr == SFR_ADDR);
   assign hit_wr       = addr_hit && sfr_wr;

   pm_tick_gen #(.MC_LEN(MC_LEN)) u_tick (
      .clk(clk), .rst_n(rst_n), .tick(tick));

   pm_reset_exit #(.HOLD_CLKS(HOLD_CLKS), .RESTART_MC(RESTART_MC)) u_rexit (
      .clk(clk), .rst_n(rst_n), .tick(tick), .ext_rst_in(ext_rst_in),
      .wdt_rst(wdt_rst), .clr(clr), .core_rst(core_rst));

   pm_wake #(.N_SRC(N_SRC), .PD_IDX_A(X0_IDX), .PD_IDX_B(X1_IDX),
             .PD_CYC_A(X0_CYC), .PD_CYC_B(X1_CYC)) u_wake (
      .clk(clk), .rst_n(rst_n), .pd(ctl_q.pd), .irq_req(irq_req),
      .irq_en(irq_en), .irq_prio(irq_prio), .insvc_hi(insvc_hi),
      .insvc_lo(insvc_lo), .idle_wake(idle_wake), .pd_wake(pd_wake));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctl_q <= '0;
      end else if (clr) begin
         ctl_q <= '0;
      end else if (hit_wr) begin
         ctl_q.pd    <= sfr_wdata[PD_POS];
         ctl_q.idle  <= sfr_wdata[IDLE_POS] && !sfr_wdata[PD_POS];
         ctl_q.flg_a <= sfr_wdata[FLGA_POS];
         ctl_q.flg_b <= sfr_wdata[FLGB_POS];
      end else begin
         if (idle_wake) ctl_q.idle <= 1'b0;
         if (pd_wake)   ctl_q.pd   <= 1'b0;
      end
   end

   assign sfr_rdata  = addr_hit ? CTL_DW'(ctl_q) : '0;
   assign cpu_clk_en = !(ctl_q.idle || ctl_q.pd);
   assign per_clk_en = !ctl_q.pd;

   a_r3_idle_keeps_periph: assert property (@(posedge clk) disable iff (!rst_n)
      (hit_wr && sfr_wdata[IDLE_POS] && !sfr_wdata[PD_POS] && !clr)
      |=> (!cpu_clk_en && per_clk_en));
   a_r4_pd_gates_both: assert property (@(posedge clk) disable iff (!rst_n)
      (hit_wr && sfr_wdata[PD_POS] && !clr) |=> (!cpu_clk_en && !per_clk_en));
   a_r4_modes_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({ctl_q.idle, ctl_q.pd}));
   a_r5_wake_opens_cpu: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_q.idle && idle_wake && !clr && !hit_wr) |=> cpu_clk_en);
   a_r8_clear_opens_clocks: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (cpu_clk_en && per_clk_en));
endmodule

// File: tb/sim_pm_ctrl.sv
module sim_pm_ctrl;
   localparam int CLK_PER = 10;

   logic       clk = 1'b0;
   logic       rst_n;
   logic [7:0] sfr_addr, sfr_wdata, sfr_rdata;
   logic       sfr_wr;
   logic [6:0] irq_req, irq_en, irq_prio;
   logic       insvc_hi, insvc_lo, ext_rst_in, wdt_rst;
   logic       cpu_clk_en, per_clk_en, core_rst;

   always #(CLK_PER / 2) clk = ~clk;

   pm_ctrl u0 (
      .clk(clk), .rst_n(rst_n), .sfr_addr(sfr_addr), .sfr_wr(sfr_wr),
      .sfr_wdata(sfr_wdata), .sfr_rdata(sfr_rdata), .irq_req(irq_req),
      .irq_en(irq_en), .irq_prio(irq_prio), .insvc_hi(insvc_hi),
      .insvc_lo(insvc_lo), .ext_rst_in(ext_rst_in), .wdt_rst(wdt_rst),
      .cpu_clk_en(cpu_clk_en), .per_clk_en(per_clk_en), .core_rst(core_rst));

   int    checks = 0;
   int    errors = 0;
   bit    done = 0;
   string tag = "R1";

   // behavioural reference state
   int m_mc, m_hold, m_rs, m_c0;
   bit m_idle, m_pd, m_fa, m_fb;

   function automatic bit m_ext_acc();
      return ext_rst_in && (m_hold >= 23);
   endfunction

   task automatic compare();
      logic [10:0] act, exp;
      logic [7:0]  erd;
      erd = (sfr_addr == 8'h87) ? {4'b0, m_fb, m_fa, m_pd, m_idle} : 8'h00;
      exp = {erd, !(m_idle || m_pd), !m_pd, (m_ext_acc() || m_rs != 0)};
      act = {sfr_rdata, cpu_clk_en, per_clk_en, core_rst};
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s act=%h exp=%h (rdata,cpu,per,rst)", tag, act, exp);
      end
   endtask

   task automatic model_step();
      bit tick, clr, hit, iw, pw, p0, p1, allowed;
      tick = (m_mc == 11);
      clr  = m_ext_acc() || wdt_rst;
      hit  = sfr_wr && (sfr_addr == 8'h87);
      iw = 0;
      for (int i = 0; i < 7; i++) begin
         allowed = irq_prio[i] ? !insvc_hi : !(insvc_hi || insvc_lo);
         if (irq_req[i] && irq_en[i] && allowed) iw = 1;
      end
      p0 = m_pd && irq_req[0] && irq_en[0];
      p1 = m_pd && irq_req[2] && irq_en[2];
      pw = (p0 && m_c0 >= 1) || p1;
      m_c0 = p0 ? 1 : 0;
      if (clr) begin
         m_idle = 0; m_pd = 0; m_fa = 0; m_fb = 0;
      end else if (hit) begin
         m_pd = sfr_wdata[1]; m_idle = sfr_wdata[0] && !sfr_wdata[1];
         m_fa = sfr_wdata[2]; m_fb = sfr_wdata[3];
      end else begin
         if (iw) m_idle = 0;
         if (pw) m_pd = 0;
      end
      m_hold = ext_rst_in ? ((m_hold < 23) ? m_hold + 1 : 23) : 0;
      if (wdt_rst) m_rs = 3;
      else if (tick && m_rs > 0) m_rs = m_rs - 1;
      m_mc = tick ? 0 : m_mc + 1;
   endtask

   task automatic cyc(int n);
      for (int k = 0; k < n; k++) begin
         #1 compare();
         @(posedge clk);
         model_step();
         @(negedge clk);
      end
   endtask

   task automatic sfr_write(logic [7:0] a, logic [7:0] d);
      sfr_addr = a; sfr_wdata = d; sfr_wr = 1;
      cyc(1);
      sfr_wr = 0; sfr_addr = 8'h87;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog (all requirements) act=running exp=finished");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      rst_n = 0; sfr_addr = 8'h87; sfr_wr = 0; sfr_wdata = 0;
      irq_req = 0; irq_en = 0; irq_prio = 0; insvc_hi = 0; insvc_lo = 0;
      ext_rst_in = 0; wdt_rst = 0;
      m_mc = 0; m_hold = 0; m_rs = 0; m_c0 = 0;
      m_idle = 0; m_pd = 0; m_fa = 0; m_fb = 0;
      repeat (3) @(negedge clk);
      rst_n = 1;
      // R1 reset state
      tag = "R1"; cyc(3);
      // R2 / R7 register access, flags as storage, foreign address ignored
      tag = "R7"; sfr_write(8'h87, 8'hFC); cyc(2);
      tag = "R2"; sfr_write(8'h86, 8'h01); cyc(1);
      sfr_addr = 8'h86; cyc(2); sfr_addr = 8'h87; cyc(1);
      // R3 idle entry
      tag = "R3"; sfr_write(8'h87, 8'h0D); cyc(3);
      // R6 blocked wake-ups
      tag = "R6";
      irq_req = 7'b0000010; cyc(3);
      irq_en = 7'b1111111; irq_prio = 7'b0000010; insvc_hi = 1; cyc(3);
      insvc_hi = 0; insvc_lo = 1; irq_req = 7'b0001000; irq_prio = 0; cyc(3);
      // R5 high priority over a low one in service
      tag = "R5"; irq_prio = 7'b0001000; cyc(3);
      irq_req = 0; insvc_lo = 0; cyc(1);
      tag = "R5"; sfr_write(8'h87, 8'h01); irq_req = 7'b1000000; irq_prio = 0; cyc(3);
      irq_req = 0;
      // R4 power-down wins over idle
      tag = "R4"; sfr_write(8'h87, 8'h07); cyc(3);
      // R10 power-down wake qualification
      tag = "R10";
      irq_req = 7'b1111010; cyc(2); irq_req = 0; cyc(1);
      irq_req = 7'b0000001; cyc(1); irq_req = 0; cyc(1);
      irq_req = 7'b0000001; cyc(3); irq_req = 0; cyc(1);
      sfr_write(8'h87, 8'h02); cyc(1);
      irq_req = 7'b0000100; cyc(2); irq_req = 0; cyc(1);
      irq_en = 0;
      // R8 external reset hold length
      tag = "R8"; sfr_write(8'h87, 8'h0D);
      ext_rst_in = 1; cyc(23); ext_rst_in = 0; cyc(3);
      ext_rst_in = 1; cyc(30); ext_rst_in = 0; cyc(3);
      // R9 watchdog restart window
      tag = "R9"; sfr_write(8'h87, 8'h0E);
      cyc(5); wdt_rst = 1; cyc(1); wdt_rst = 0; cyc(45);
      sfr_write(8'h87, 8'h01); cyc(7); wdt_rst = 1; cyc(1); wdt_rst = 0; cyc(45);
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule